// File: doc/BRIEF.md
# Dual-Port RAM with Per-Port Aspect Ratio

This block is a synthesizable behavioural model of a true dual-port synchronous RAM. It holds 4608 bits. Port A and port B each have their own clock, a 12-bit address and 9-bit input and output data buses. Each port also has an active-low select and an active-low write strobe. Static strap inputs set three things for each port. The first is its geometry: 4096 words of 1 bit, 2048 of 2, 1024 of 4, or 512 of 9. The second is whether read data passes through one extra output register. The third is whether a write shows the written data on the output or leaves the last read value in place. Because the straps are set per port, one port can fill the array in one shape while the other reads it back in another.

The storage is 4096 ordinary bits plus 512 extra bits. In the 1-, 2- and 4-bit geometries, word `a` of width `w` occupies ordinary bits `a*w` through `a*w+w-1`. In the 9-bit geometry, word `a` holds ordinary bits `8a..8a+7` in its low eight positions, and its own extra bit in position 8. The extra bits can only be reached in the 9-bit geometry.

A shared active-low reset drives both outputs to zero and clears the output registers. While it is low it suppresses every access. It does not touch the stored bits. The straps may only change while reset is held.

Top module: `dpram_aspect`

## Requirements
- R1: A 2-bit geometry strap chooses the port shape: 00 gives 4096×1 (address bits [11:0], data bit [0]), 01 gives 2048×2 (address [10:0], data [1:0]), 10 gives 1024×4 (address [9:0], data [3:0]), and 11 gives 512×9 (address [8:0], data [8:0]).
- R2: Word `a` of width w∈{1,2,4} maps to ordinary bits a·w..a·w+w−1, with data bit j stored at ordinary bit a·w+j. A 9-bit word `a` maps data bits [7:0] to ordinary bits 8a..8a+7 and data bit [8] to extra bit `a`. Narrow writes never change an extra bit.
- R3: In the 1-, 2- and 4-bit geometries, the output bits above the active width are always zero.
- R4: While the active-low select is high, the port performs no access and its output keeps its value, even if the write strobe is low.
- R5: With select low, a low write strobe at the clock edge stores the masked input word, and a high write strobe reads the addressed word.
- R6: With the latency strap low, read data appears on the output after the clock edge that samples the read. With it high, the data appears one edge later, provided the port is still selected at that second edge.
- R7: During a write, a low write-mode strap leaves the output unchanged. A high write-mode strap places the written word, masked to the active width, on the output after the edge. Reads are not affected by this strap.
- R8: While reset is low, both outputs are zero and no write changes the array. After reset is released, the outputs start from zero and all stored bits are as they were before reset.
- R9: When both ports share a clock and write the same bit at the same edge, port A's value is stored. Bits in the same word that only one port writes keep that port's value. A read at the same edge as a write to the same location by the other port returns the old data.
- R10: Data written through one port in one geometry reads back through the other port in any other geometry according to the bit mapping of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Shared active-low reset of outputs and output registers |
| geo_a | input | 2 | Port A geometry strap |
| lat_a | input | 1 | Port A extra output register enable |
| wthru_a | input | 1 | Port A write-through output enable |
| sel_n_a | input | 1 | Port A active-low select |
| wr_n_a | input | 1 | Port A active-low write strobe |
| addr_a | input | 12 | Port A word address |
| din_a | input | 9 | Port A write data |
| dout_a | output | 9 | Port A read data |
| geo_b | input | 2 | Port B geometry strap |
| lat_b | input | 1 | Port B extra output register enable |
| wthru_b | input | 1 | Port B write-through output enable |
| sel_n_b | input | 1 | Port B active-low select |
| wr_n_b | input | 1 | Port B active-low write strobe |
| addr_b | input | 12 | Port B word address |
| din_b | input | 9 | Port B write data |
| dout_b | output | 9 | Port B read data |

## Verification
The bench fills the whole array in one geometry and reads all of it back in another, across the 1/9, 4/2 and 9/1 port pairings. A wrong lane offset or row split therefore shows up as a scrambled bit pattern, and a narrow write that disturbs an extra bit shows up as a wrong bit 8 in the 9-bit read-back. It aims one read at the edge where the registered output must still show the previous word, so a latency path that is missing or doubled is caught. It also checks that a deselected port keeps its output through a low write strobe, and that a write-hold port does not leak write data. A reset that wipes the array, or lets a write through, changes a later read. The two-port checks cover a same-bit write collision, where the wrong winner leaves port B's value, and a read-during-write, where a port that forwards new data returns the inverse of the expected value.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    localparam int WORD_W = 9;

    typedef enum logic [1:0] {
        GEO_X1 = 2'b00,
        GEO_X2 = 2'b01,
        GEO_X4 = 2'b10,
        GEO_X9 = 2'b11
    } geo_e;

    // Mask of the data bits that a geometry uses.
    function automatic logic [WORD_W-1:0] lane_of(geo_e g);
        case (g)
            GEO_X1:  return WORD_W'(9'h001);
            GEO_X2:  return WORD_W'(9'h003);
            GEO_X4:  return WORD_W'(9'h00F);
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/dpram_port_map.sv
module dpram_port_map
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = WORD_W,
    parameter int ROWS   = 512
) (
    input  geo_e                        geo,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           din,
    input  logic [DATA_W-1:0]           row_val,
    output logic [$clog2(ROWS)-1:0]     row,
    output logic [DATA_W-1:0]           wmask,
    output logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           wlane,
    output logic [DATA_W-1:0]           rdata
);
    localparam int ROW_AW = $clog2(ROWS);
    localparam int OFF_W  = $clog2(DATA_W);

    logic [OFF_W-1:0]  off;
    logic [DATA_W-1:0] lane;

    always_comb begin
        lane = lane_of(geo);
        case (geo)
            GEO_X1: begin
                row = ROW_AW'(addr >> 3);
                off = OFF_W'(addr[2:0]);
            end
            GEO_X2: begin
                row = ROW_AW'(addr >> 2);
                off = OFF_W'({addr[1:0], 1'b0});
            end
            GEO_X4: begin
                row = ROW_AW'(addr >> 1);
                off = OFF_W'({addr[0], 2'b00});
            end
            default: begin
                row = ROW_AW'(addr);
                off = '0;
            end
        endcase
        wlane = din & lane;
        wmask = lane << off;
        wdata = wlane << off;
        rdata = (row_val >> off) & lane;
    end

endmodule

// File: rtl/dpram_port_out.sv
module dpram_port_out #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              lat,
    input  logic              wthru,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] wlane,
    output logic [DATA_W-1:0] dout
);
    typedef struct packed {
        logic [DATA_W-1:0] rd;
        logic [DATA_W-1:0] pp;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d = '0;
        end else if (!sel_n) begin
            if (wr_n) begin
                st_d.rd = rdata;
            end else if (wthru) begin
                st_d.rd = wlane;
            end
            st_d.pp = st_q.rd;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = !rst_n ? '0 : (lat ? st_q.pp : st_q.rd);

endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
    parameter int ROWS  = 512,
    parameter int ROW_W = 9
) (
    input  logic                    clk_a,
    input  logic                    clk_b,
    input  logic                    wr_a,
    input  logic [$clog2(ROWS)-1:0] row_a,
    input  logic [ROW_W-1:0]        mask_a,
    input  logic [ROW_W-1:0]        data_a,
    input  logic                    wr_b,
    input  logic [$clog2(ROWS)-1:0] row_b,
    input  logic [ROW_W-1:0]        mask_b,
    input  logic [ROW_W-1:0]        data_b,
    output logic [ROW_W-1:0]        val_a,
    output logic [ROW_W-1:0]        val_b
);
    // Each port owns one plane; a stored bit is the XOR of both planes,
    // so each plane has a single writer clock.
    logic [ROW_W-1:0] plane_a [ROWS];
    logic [ROW_W-1:0] plane_b [ROWS];
    logic [ROW_W-1:0] mask_b_eff;

    always_comb begin
        mask_b_eff = mask_b;
        if (wr_a && (row_a == row_b)) begin
            mask_b_eff = mask_b & ~mask_a;
        end
    end

    always_ff @(posedge clk_a) begin
        if (wr_a) begin
            plane_a[row_a] <= (plane_a[row_a] & ~mask_a)
                            | ((data_a ^ plane_b[row_a]) & mask_a);
        end
    end

    always_ff @(posedge clk_b) begin
        if (wr_b) begin
            plane_b[row_b] <= (plane_b[row_b] & ~mask_b_eff)
                            | ((data_b ^ plane_a[row_b]) & mask_b_eff);
        end
    end

    assign val_a = plane_a[row_a] ^ plane_b[row_a];
    assign val_b = plane_a[row_b] ^ plane_b[row_b];

endmodule

// File: rtl/dpram_aspect.sv
module dpram_aspect
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = WORD_W,
    parameter int ROWS   = 512
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst_n,
    input  logic [1:0]        geo_a,
    input  logic              lat_a,
    input  logic              wthru_a,
    input  logic              sel_n_a,
    input  logic              wr_n_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DATA_W-1:0] din_a,
    output logic [DATA_W-1:0] dout_a,
    input  logic [1:0]        geo_b,
    input  logic              lat_b,
    input  logic              wthru_b,
    input  logic              sel_n_b,
    input  logic              wr_n_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] din_b,
    output logic [DATA_W-1:0] dout_b
);
    localparam int NPORT  = 2;
    localparam int ROW_AW = $clog2(ROWS);

    logic              p_clk   [NPORT];
    logic [1:0]        p_geo   [NPORT];
    logic              p_lat   [NPORT];
    logic              p_wthru [NPORT];
    logic              p_sel_n [NPORT];
    logic              p_wr_n  [NPORT];
    logic [ADDR_W-1:0] p_addr  [NPORT];
    logic [DATA_W-1:0] p_din   [NPORT];
    logic [DATA_W-1:0] p_dout  [NPORT];
    logic [ROW_AW-1:0] p_row   [NPORT];
    logic [DATA_W-1:0] p_wmask [NPORT];
    logic [DATA_W-1:0] p_wdata [NPORT];
    logic [DATA_W-1:0] p_wlane [NPORT];
    logic [DATA_W-1:0] p_rdata [NPORT];
    logic [DATA_W-1:0] p_val   [NPORT];
    logic              p_wr    [NPORT];

    assign p_clk[0] = clk_a;   assign p_clk[1] = clk_b;
    assign p_geo[0] = geo_a;   assign p_geo[1] = geo_b;
    assign p_lat[0] = lat_a;   assign p_lat[1] = lat_b;
    assign p_wthru[0] = wthru_a; assign p_wthru[1] = wthru_b;
    assign p_sel_n[0] = sel_n_a; assign p_sel_n[1] = sel_n_b;
    assign p_wr_n[0] = wr_n_a; assign p_wr_n[1] = wr_n_b;
    assign p_addr[0] = addr_a; assign p_addr[1] = addr_b;
    assign p_din[0] = din_a;   assign p_din[1] = din_b;
    assign dout_a = p_dout[0];
    assign dout_b = p_dout[1];

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        assign p_wr[i] = rst_n & ~p_sel_n[i] & ~p_wr_n[i];

        dpram_port_map #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .ROWS   (ROWS)
        ) u_map (
            .geo     (geo_e'(p_geo[i])),
            .addr    (p_addr[i]),
            .din     (p_din[i]),
            .row_val (p_val[i]),
            .row     (p_row[i]),
            .wmask   (p_wmask[i]),
            .wdata   (p_wdata[i]),
            .wlane   (p_wlane[i]),
            .rdata   (p_rdata[i])
        );

        dpram_port_out #(
            .DATA_W (DATA_W)
        ) u_out (
            .clk   (p_clk[i]),
            .rst_n (rst_n),
            .sel_n (p_sel_n[i]),
            .wr_n  (p_wr_n[i]),
            .lat   (p_lat[i]),
            .wthru (p_wthru[i]),
            .rdata (p_rdata[i]),
            .wlane (p_wlane[i]),
            .dout  (p_dout[i])
        );
    end

    dpram_store #(
        .ROWS  (ROWS),
        .ROW_W (DATA_W)
    ) u_store (
        .clk_a  (clk_a),
        .clk_b  (clk_b),
        .wr_a   (p_wr[0]),
        .row_a  (p_row[0]),
        .mask_a (p_wmask[0]),
        .data_a (p_wdata[0]),
        .wr_b   (p_wr[1]),
        .row_b  (p_row[1]),
        .mask_b (p_wmask[1]),
        .data_b (p_wdata[1]),
        .val_a  (p_val[0]),
        .val_b  (p_val[1])
    );

endmodule

// File: rtl/dpram_aspect_chk.sv
module dpram_aspect_chk
    import dpram_pkg::*;
(
    input logic       clk_a,
    input logic       clk_b,
    input logic       rst_n,
    input logic [1:0] geo_a,
    input logic       lat_a,
    input logic       wthru_a,
    input logic       sel_n_a,
    input logic       wr_n_a,
    input logic [8:0] din_a,
    input logic [8:0] dout_a,
    input logic [1:0] geo_b,
    input logic       lat_b,
    input logic       wthru_b,
    input logic       sel_n_b,
    input logic       wr_n_b,
    input logic [8:0] din_b,
    input logic [8:0] dout_b
);
    // R8: first sample after reset release shows cleared registers
    p_release_zero_a_r8: assert property (@(posedge clk_a)
        (rst_n && $past(!rst_n)) |-> (dout_a == 9'd0));
    p_release_zero_b_r8: assert property (@(posedge clk_b)
        (rst_n && $past(!rst_n)) |-> (dout_b == 9'd0));

    // R4: deselected port keeps its output
    p_idle_hold_a_r4: assert property (@(posedge clk_a) disable iff (!rst_n)
        sel_n_a |=> $stable(dout_a));
    p_idle_hold_b_r4: assert property (@(posedge clk_b) disable iff (!rst_n)
        sel_n_b |=> $stable(dout_b));

    // R3: bits above the active width stay zero
    p_upper_zero_a_r3: assert property (@(posedge clk_a) disable iff (!rst_n)
        (geo_a != 2'b11) |-> ((dout_a & ~lane_of(geo_e'(geo_a))) == 9'd0));
    p_upper_zero_b_r3: assert property (@(posedge clk_b) disable iff (!rst_n)
        (geo_b != 2'b11) |-> ((dout_b & ~lane_of(geo_e'(geo_b))) == 9'd0));

    // R7: write-through shows masked write data; write-hold keeps output
    p_wthru_a_r7: assert property (@(posedge clk_a) disable iff (!rst_n)
        (!sel_n_a && !wr_n_a && wthru_a && !lat_a)
        |=> (dout_a == ($past(din_a) & lane_of(geo_e'(geo_a)))));
    p_whold_a_r7: assert property (@(posedge clk_a) disable iff (!rst_n)
        (!sel_n_a && !wr_n_a && !wthru_a && !lat_a) |=> $stable(dout_a));
    p_wthru_b_r7: assert property (@(posedge clk_b) disable iff (!rst_n)
        (!sel_n_b && !wr_n_b && wthru_b && !lat_b)
        |=> (dout_b == ($past(din_b) & lane_of(geo_e'(geo_b)))));
    p_whold_b_r7: assert property (@(posedge clk_b) disable iff (!rst_n)
        (!sel_n_b && !wr_n_b && !wthru_b && !lat_b) |=> $stable(dout_b));

endmodule

bind dpram_aspect dpram_aspect_chk u_chk (
    .clk_a   (clk_a),
    .clk_b   (clk_b),
    .rst_n   (rst_n),
    .geo_a   (geo_a),
    .lat_a   (lat_a),
    .wthru_a (wthru_a),
    .sel_n_a (sel_n_a),
    .wr_n_a  (wr_n_a),
    .din_a   (din_a),
    .dout_a  (dout_a),
    .geo_b   (geo_b),
    .lat_b   (lat_b),
    .wthru_b (wthru_b),
    .sel_n_b (sel_n_b),
    .wr_n_b  (wr_n_b),
    .din_b   (din_b),
    .dout_b  (dout_b)
);

// File: tb/dpram_aspect_tb.sv
module dpram_aspect_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic        rst_n = 1'b0;
    logic [1:0]  geo_a = 2'b00, geo_b = 2'b00;
    logic        lat_a = 1'b0, lat_b = 1'b0;
    logic        wthru_a = 1'b0, wthru_b = 1'b0;
    logic        sel_n_a = 1'b1, sel_n_b = 1'b1;
    logic        wr_n_a = 1'b1, wr_n_b = 1'b1;
    logic [11:0] addr_a = '0, addr_b = '0;
    logic [8:0]  din_a = '0, din_b = '0;
    logic [8:0]  dout_a, dout_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    bit ref_d [4096];
    bit ref_n [512];

    dpram_aspect u_dut (
        .clk_a(clk), .clk_b(clk), .rst_n(rst_n),
        .geo_a(geo_a), .lat_a(lat_a), .wthru_a(wthru_a), .sel_n_a(sel_n_a),
        .wr_n_a(wr_n_a), .addr_a(addr_a), .din_a(din_a), .dout_a(dout_a),
        .geo_b(geo_b), .lat_b(lat_b), .wthru_b(wthru_b), .sel_n_b(sel_n_b),
        .wr_n_b(wr_n_b), .addr_b(addr_b), .din_b(din_b), .dout_b(dout_b)
    );

    task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int width_of(int g);
        case (g)
            0: return 1;
            1: return 2;
            2: return 4;
            default: return 8;
        endcase
    endfunction

    function automatic logic [8:0] ref_word(int g, int a);
        logic [8:0] w = '0;
        int wd = width_of(g);
        for (int j = 0; j < wd; j++) w[j] = ref_d[a * wd + j];
        if (g == 3) w[8] = ref_n[a];
        return w;
    endfunction

    task automatic ref_put(int g, int a, logic [8:0] d);
        int wd = width_of(g);
        for (int j = 0; j < wd; j++) ref_d[a * wd + j] = d[j];
        if (g == 3) ref_n[a] = d[8];
    endtask

    function automatic logic [8:0] pat(int k);
        return 9'((k * 37 + 11) ^ (k >> 2) ^ (k << 3));
    endfunction

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reset_cfg(logic [1:0] ga, logic la, logic ta,
                             logic [1:0] gb, logic lb, logic tb);
        rst_n = 1'b0;
        sel_n_a = 1'b1; sel_n_b = 1'b1; wr_n_a = 1'b1; wr_n_b = 1'b1;
        geo_a = ga; lat_a = la; wthru_a = ta;
        geo_b = gb; lat_b = lb; wthru_b = tb;
        cycle();
        cycle();
        rst_n = 1'b1;
        cycle();
    endtask

    task automatic op_a(logic wr, int a, logic [8:0] d);
        sel_n_a = 1'b0; wr_n_a = ~wr; addr_a = 12'(a); din_a = d;
        cycle();
        sel_n_a = 1'b1; wr_n_a = 1'b1;
        if (wr) ref_put(int'(geo_a), a, d);
    endtask

    task automatic op_b(logic wr, int a, logic [8:0] d);
        sel_n_b = 1'b0; wr_n_b = ~wr; addr_b = 12'(a); din_b = d;
        cycle();
        sel_n_b = 1'b1; wr_n_b = 1'b1;
        if (wr) ref_put(int'(geo_b), a, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [8:0] prev;
        logic       vx, vy, old;
        int         x, y;

        // ---- Phase 1: B in 512x9 fills, A in 4096x1 overwrites data bits
        reset_cfg(2'b00, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0);
        chk("R8 reset out a", dout_a, 9'd0);
        chk("R8 reset out b", dout_b, 9'd0);
        for (int a = 0; a < 512; a++) op_b(1'b1, a, pat(a));
        for (int k = 0; k < 4096; k++) op_a(1'b1, k, {8'd0, pat(k + 5)[3]});
        for (int k = 0; k < 4096; k += 37) begin
            op_a(1'b0, k, '0);
            chk("R1 R3 x1 read a", dout_a, ref_word(0, k));
        end
        for (int a = 0; a < 512; a++) begin
            op_b(1'b0, a, '0);
            chk("R2 R10 x9 readback b", dout_b, ref_word(3, a));
        end

        // ---- Phase 2: A 1024x4 writes, B 2048x2 reads
        reset_cfg(2'b10, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0);
        for (int a = 0; a < 1024; a++) op_a(1'b1, a, pat(a * 3 + 1) | 9'h1F0);
        for (int a = 0; a < 2048; a++) begin
            op_b(1'b0, a, '0);
            chk("R10 R3 x2 readback b", dout_b, ref_word(1, a));
        end

        // ---- Phase 3: A 512x9 write-through, B 4096x1 registered, write-hold
        reset_cfg(2'b11, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0);
        for (int a = 0; a < 64; a++) begin
            op_a(1'b1, a, pat(a + 100));
            chk("R7 write-through a", dout_a, pat(a + 100));
        end
        op_a(1'b0, 200, '0);
        chk("R2 R5 ninth bit kept a", dout_a, ref_word(3, 200));

        x = 40;
        vx = ref_d[x];
        y = 41;
        while (ref_d[y] == vx) y++;
        vy = ref_d[y];
        sel_n_b = 1'b0; wr_n_b = 1'b1; addr_b = 12'(x);
        cycle();
        cycle();
        chk("R6 registered read x", dout_b, {8'd0, vx});
        addr_b = 12'(y);
        cycle();
        chk("R6 one edge later still x", dout_b, {8'd0, vx});
        cycle();
        chk("R6 registered read y", dout_b, {8'd0, vy});
        wr_n_b = 1'b0; addr_b = 12'(x); din_b = {8'h1F, ~vx};
        cycle();
        ref_d[x] = ~vx;
        chk("R7 write-hold b", dout_b, {8'd0, vy});
        sel_n_b = 1'b1; wr_n_b = 1'b1;
        cycle();
        chk("R7 R4 hold after write b", dout_b, {8'd0, vy});
        sel_n_b = 1'b0; addr_b = 12'(x);
        cycle();
        cycle();
        sel_n_b = 1'b1;
        chk("R5 read after write b", dout_b, {8'd0, ~vx});

        op_a(1'b0, 9, '0);
        prev = dout_a;
        sel_n_a = 1'b1; wr_n_a = 1'b0; addr_a = 12'd9; din_a = ~prev;
        cycle();
        cycle();
        chk("R4 deselected output a", dout_a, prev);
        wr_n_a = 1'b1;
        op_a(1'b0, 9, '0);
        chk("R4 deselected no write a", dout_a, ref_word(3, 9));

        rst_n = 1'b0;
        sel_n_a = 1'b0; wr_n_a = 1'b0; addr_a = 12'd7; din_a = ~ref_word(3, 7);
        cycle();
        cycle();
        chk("R8 reset zero a", dout_a, 9'd0);
        chk("R8 reset zero b", dout_b, 9'd0);
        sel_n_a = 1'b1; wr_n_a = 1'b1; rst_n = 1'b1;
        cycle();
        chk("R8 release zero a", dout_a, 9'd0);
        op_a(1'b0, 7, '0);
        chk("R8 memory kept and write blocked", dout_a, ref_word(3, 7));

        // ---- Phase 4: both 4096x1 on a shared clock, collisions
        reset_cfg(2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
        sel_n_a = 1'b0; wr_n_a = 1'b0; addr_a = 12'd9; din_a = 9'd1;
        sel_n_b = 1'b0; wr_n_b = 1'b0; addr_b = 12'd9; din_b = 9'd0;
        cycle();
        ref_d[9] = 1'b1;
        sel_n_b = 1'b1; wr_n_b = 1'b1;
        wr_n_a = 1'b1;
        cycle();
        chk("R9 port A wins same bit", dout_a, 9'd1);

        old = ref_d[10];
        wr_n_a = 1'b0; addr_a = 12'd10; din_a = {8'd0, ~old};
        sel_n_b = 1'b0; wr_n_b = 1'b1; addr_b = 12'd10;
        cycle();
        ref_d[10] = ~old;
        sel_n_a = 1'b1; wr_n_a = 1'b1;
        chk("R9 read during write old data", dout_b, {8'd0, old});
        cycle();
        chk("R9 read after write new data", dout_b, {8'd0, ~old});
        sel_n_b = 1'b1;

        sel_n_a = 1'b0; wr_n_a = 1'b0; addr_a = 12'd16; din_a = 9'd1;
        sel_n_b = 1'b0; wr_n_b = 1'b0; addr_b = 12'd17; din_b = 9'd0;
        cycle();
        ref_d[16] = 1'b1; ref_d[17] = 1'b0;
        sel_n_a = 1'b1; wr_n_a = 1'b1; sel_n_b = 1'b1; wr_n_b = 1'b1;
        op_a(1'b0, 17, '0);
        chk("R9 same word other bit from B", dout_a, 9'd0);
        op_b(1'b0, 16, '0);
        chk("R9 same word other bit from A", dout_b, 9'd1);

        // ---- Final: ninth bits read back in 9-bit view after all narrow writes
        reset_cfg(2'b11, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0);
        for (int a = 0; a < 512; a += 5) begin
            op_b(1'b0, a, '0);
            chk("R2 R10 final x9 view", dout_b, ref_word(3, a));
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule